// File: doc/BRIEF.md
# Parallel Flash Bus-Mode and Command Controller

This block gives the control behaviour of a 16-bit parallel flash device as synchronous logic. It watches the chip-enable, output-enable, write-enable and reset/power-down pins and decodes four bus states from them: read, output disabled, standby and deep power-down. The data bus is split into an input word, an output word and an output-drive enable. A command interface captures bytes on the rising edge of write enable and selects what a read returns: the word array, the identifier codes or the status register. The same interface starts block erase and word program.

Erase and program act on a small internal word array. Each runs for a fixed number of clock cycles, and a ready/busy pin reports its progress. While an operation is running, every read returns the status word. Pulling the power-down pin low for long enough resets the command interface and aborts any operation in progress. The words that operation targeted are then marked corrupt, and after the pin is released two wake-up windows apply: one before reads are valid and a longer one before commands are taken. Every timing figure is a parameter counted in clock cycles.

Top module: `flash_bus_ctrl`

## Requirements
- R1: While `ce_n` is high, `dq_oe` is low whatever the level of `oe_n` (standby).
- R2: While `oe_n` is high, `dq_oe` is low. With `ce_n` and `oe_n` both low, `rp_n` high and no wake window running, `dq_oe` is high and `dq_out` carries the selected read word. After reset every array word reads 0xFFFF.
- R3: A command byte is `dq_in[7:0]`, taken on a clock edge where `we_n` has risen from low while `ce_n` is low. A `we_n` pulse while `ce_n` is high is ignored. 0xFF selects array read, 0x90 identifier read and 0x70 status read.
- R4: In identifier read, address 0 returns 0x00A5, address 1 returns 0x0C3E and every other address returns 0x0000.
- R5: Command 0x40 followed by one write cycle programs `dq_in` at `addr` and runs busy for T_WRITE cycles. While busy, `ry_by_n` is low and any read returns the status word {8'h00, ready, 7 stored bits}, in which bit 7 = 1 means idle. After completion the status reads 0x0080 and array read returns the programmed word.
- R6: Command 0x20 followed by 0xD0 at any address inside a block of 2^BLK_W aligned words sets that block to 0xFFFF after T_ERASE busy cycles. Other blocks are not changed.
- R7: A byte other than 0xD0 after 0x20 sets status bits 5 and 4 (status reads 0x00B0), starts no erase and leaves read mode at status. Command 0x50 clears status bits 5:3.
- R8: Raising `ce_n` during an operation does not stop it, and the operation completes.
- R9: `rp_n` low forces `dq_oe` low. If it is held low for at least T_RPL sampled cycles, the read mode becomes array read and the stored status bits clear (status 0x0080). A shorter low pulse changes no state.
- R10: An accepted power-down during erase or program ends the operation and keeps `ry_by_n` low until the wake-up period ends. Each target word of the aborted operation then reads 0xDEAD.
- R11: After an accepted power-down releases, `dq_oe` stays low for T_PHQV cycles, and command writes made before T_PHWL cycles have passed are ignored.
- R12: Command writes made while an operation is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; commands taken on its rising edge |
| rp_n | input | 1 | Reset / deep power-down, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data bus, input side |
| dq_out | output | 16 | Data bus, output side |
| dq_oe | output | 1 | Drive enable for the data bus |
| ry_by_n | output | 1 | Ready (high) / busy (low) |

## Verification
The hardest case to reach is an abort: a power-down must arrive while an erase is still counting and must be held past the minimum low time. The wake windows that follow its release must also be observed. The bench starts an erase, waits a few cycles, holds `rp_n` low past T_RPL and checks that `ry_by_n` stays low through release. It writes a command inside the wake window to show that it is ignored, then reads the aborted block in array mode and expects the corrupt marker. A separate low pulse shorter than T_RPL confirms that no state is touched.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    typedef enum logic [1:0] {MODE_ARRAY, MODE_IDENT, MODE_STATUS} rd_mode_e;
    typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_WRITE} phase_e;
    typedef enum logic [1:0] {PD_RUN, PD_LOW, PD_WAKE} pd_state_e;
    typedef enum logic [1:0] {OP_NONE, OP_ERASE, OP_WRITE} op_e;

    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_WRITE   = 8'h40;

    localparam logic [15:0] MFR_CODE = 16'h00A5;
    localparam logic [15:0] DEV_CODE = 16'h0C3E;
    localparam logic [15:0] ERASED   = 16'hFFFF;
    localparam logic [15:0] CORRUPT  = 16'hDEAD;

    localparam logic [6:0] ERR_SEQ   = 7'h30;
    localparam logic [6:0] CLR_MASK  = 7'h38;

    function automatic logic [15:0] ident_word(input logic at0, input logic at1);
        if (at0)      return MFR_CODE;
        else if (at1) return DEV_CODE;
        else          return 16'h0000;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fbc_wr_detect.sv
module fbc_wr_detect (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    output logic stb_o
);
    logic we_q;

    always_ff @(posedge clk) begin
        if (rst) we_q <= 1'b1;
        else     we_q <= we_n;
    end

    assign stb_o = !ce_n && we_n && !we_q;

    a_r3_strobe_needs_ce: assert property (@(posedge clk) disable iff (rst)
        stb_o |-> !ce_n && $past(!we_n));

endmodule

// File: rtl/fbc_pd_timer.sv
module fbc_pd_timer
    import fbc_pkg::*;
#(
    parameter int T_RPL  = 5,
    parameter int T_PHQV = 8,
    parameter int T_PHWL = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic rp_n,
    output logic accept_o,
    output logic rd_en_o,
    output logic cmd_en_o,
    output logic run_o
);
    localparam int T_WAKE = max2(T_PHQV, T_PHWL);
    localparam int CMAX   = max2(T_RPL, T_WAKE);
    localparam int CW     = $clog2(CMAX + 1);

    pd_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic acc_q;

    assign accept_o = (state_q == PD_LOW) && !rp_n && !acc_q && (cnt_q == CW'(T_RPL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PD_RUN;
            cnt_q   <= '0;
            acc_q   <= 1'b0;
        end else begin
            case (state_q)
                PD_RUN: if (!rp_n) begin
                    state_q <= PD_LOW;
                    cnt_q   <= CW'(1);
                    acc_q   <= 1'b0;
                end
                PD_LOW: begin
                    if (rp_n) begin
                        state_q <= acc_q ? PD_WAKE : PD_RUN;
                        cnt_q   <= '0;
                    end else begin
                        if (accept_o) acc_q <= 1'b1;
                        if (cnt_q != CW'(T_RPL)) cnt_q <= cnt_q + 1'b1;
                    end
                end
                PD_WAKE: begin
                    if (!rp_n) begin
                        state_q <= PD_LOW;
                        cnt_q   <= CW'(1);
                        acc_q   <= 1'b0;
                    end else if (cnt_q == CW'(T_WAKE - 1)) begin
                        state_q <= PD_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= PD_RUN;
            endcase
        end
    end

    assign run_o    = (state_q == PD_RUN);
    assign rd_en_o  = rp_n && (run_o || (state_q == PD_WAKE && cnt_q >= CW'(T_PHQV)));
    assign cmd_en_o = rp_n && (run_o || (state_q == PD_WAKE && cnt_q >= CW'(T_PHWL)));

    a_r9_accept_after_low: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> $past(!rp_n));

    a_r11_first_wake_cycle_blocked: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q == PD_LOW) && $past(acc_q) && rp_n) |-> !cmd_en_o && !rd_en_o);

endmodule

// File: rtl/fbc_engine.sv
module fbc_engine
    import fbc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int WORDS   = 16,
    parameter int BLK_W   = 2,
    parameter int T_ERASE = 20,
    parameter int T_WRITE = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              cmd_en,
    input  logic              accept,
    input  logic              pd_run,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       rdata_o,
    output logic              ry_by_n_o
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int BW    = $clog2(max2(T_ERASE, T_WRITE) + 1);

    logic [15:0]      mem [WORDS];
    rd_mode_e         mode_q;
    phase_e           phase_q;
    op_e              op_q;
    logic             busy_q, hold_q;
    logic [BW-1:0]    cnt_q;
    logic [6:0]       stat_q;
    logic [IDX_W-1:0] tgt_q;
    logic [15:0]      tdata_q;
    logic [IDX_W-1:0] idx;
    logic [7:0]       cmd;
    logic [15:0]      status_word;

    assign idx         = addr[IDX_W-1:0];
    assign cmd         = dq_in[7:0];
    assign status_word = {8'h00, !busy_q, stat_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= ERASED;
            mode_q  <= MODE_ARRAY;
            phase_q <= PH_IDLE;
            op_q    <= OP_NONE;
            busy_q  <= 1'b0;
            hold_q  <= 1'b0;
            cnt_q   <= '0;
            stat_q  <= '0;
            tgt_q   <= '0;
            tdata_q <= '0;
        end else begin
            if (accept && busy_q) hold_q <= 1'b1;
            else if (pd_run)      hold_q <= 1'b0;

            if (accept) begin
                if (busy_q) begin
                    for (int i = 0; i < WORDS; i++)
                        if ((op_q == OP_WRITE && IDX_W'(i) == tgt_q) ||
                            (op_q == OP_ERASE && (IDX_W'(i) >> BLK_W) == (tgt_q >> BLK_W)))
                            mem[i] <= CORRUPT;
                end
                busy_q  <= 1'b0;
                op_q    <= OP_NONE;
                mode_q  <= MODE_ARRAY;
                phase_q <= PH_IDLE;
                stat_q  <= '0;
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                    op_q   <= OP_NONE;
                    for (int i = 0; i < WORDS; i++) begin
                        if (op_q == OP_WRITE && IDX_W'(i) == tgt_q) mem[i] <= tdata_q;
                        if (op_q == OP_ERASE && (IDX_W'(i) >> BLK_W) == (tgt_q >> BLK_W))
                            mem[i] <= ERASED;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (stb && cmd_en) begin
                case (phase_q)
                    PH_ERASE: begin
                        phase_q <= PH_IDLE;
                        mode_q  <= MODE_STATUS;
                        if (cmd == CMD_CONFIRM) begin
                            busy_q <= 1'b1;
                            op_q   <= OP_ERASE;
                            tgt_q  <= idx;
                            cnt_q  <= BW'(T_ERASE - 1);
                        end else begin
                            stat_q <= stat_q | ERR_SEQ;
                        end
                    end
                    PH_WRITE: begin
                        phase_q <= PH_IDLE;
                        mode_q  <= MODE_STATUS;
                        busy_q  <= 1'b1;
                        op_q    <= OP_WRITE;
                        tgt_q   <= idx;
                        tdata_q <= dq_in;
                        cnt_q   <= BW'(T_WRITE - 1);
                    end
                    default: begin
                        case (cmd)
                            CMD_ARRAY:  mode_q <= MODE_ARRAY;
                            CMD_IDENT:  mode_q <= MODE_IDENT;
                            CMD_STATUS: mode_q <= MODE_STATUS;
                            CMD_CLEAR:  stat_q <= stat_q & ~CLR_MASK;
                            CMD_ERASE:  begin phase_q <= PH_ERASE; mode_q <= MODE_STATUS; end
                            CMD_WRITE:  begin phase_q <= PH_WRITE; mode_q <= MODE_STATUS; end
                            default: ;
                        endcase
                    end
                endcase
            end
        end
    end

    always_comb begin
        if (busy_q) rdata_o = status_word;
        else begin
            case (mode_q)
                MODE_IDENT:  rdata_o = ident_word(addr == '0, addr == ADDR_W'(1));
                MODE_STATUS: rdata_o = status_word;
                default:     rdata_o = mem[idx];
            endcase
        end
    end

    assign ry_by_n_o = !(busy_q || hold_q);

    a_r10_abort_ends_op: assert property (@(posedge clk) disable iff (rst)
        accept |=> !busy_q && mode_q == MODE_ARRAY && stat_q == '0);

    a_r10_abort_keeps_busy_pin: assert property (@(posedge clk) disable iff (rst)
        (accept && busy_q) |=> !ry_by_n_o);

    a_r5_busy_reads_status: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> rdata_o[7] == 1'b0 && !ry_by_n_o);

    a_r12_busy_runs_on: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0 && !accept) |=> busy_q && $stable(mode_q) && $stable(tgt_q));

endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
    import fbc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int WORDS   = 16,
    parameter int BLK_W   = 2,
    parameter int T_RPL   = 5,
    parameter int T_PHQV  = 8,
    parameter int T_PHWL  = 12,
    parameter int T_ERASE = 20,
    parameter int T_WRITE = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              rp_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic              dq_oe,
    output logic              ry_by_n
);
    logic stb, accept, rd_en, cmd_en, pd_run;
    logic [15:0] rdata;

    fbc_wr_detect u_wr (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .stb_o(stb)
    );

    fbc_pd_timer #(.T_RPL(T_RPL), .T_PHQV(T_PHQV), .T_PHWL(T_PHWL)) u_pd (
        .clk(clk), .rst(rst), .rp_n(rp_n), .accept_o(accept),
        .rd_en_o(rd_en), .cmd_en_o(cmd_en), .run_o(pd_run)
    );

    fbc_engine #(.ADDR_W(ADDR_W), .WORDS(WORDS), .BLK_W(BLK_W),
                 .T_ERASE(T_ERASE), .T_WRITE(T_WRITE)) u_eng (
        .clk(clk), .rst(rst), .stb(stb), .cmd_en(cmd_en), .accept(accept),
        .pd_run(pd_run), .addr(addr), .dq_in(dq_in),
        .rdata_o(rdata), .ry_by_n_o(ry_by_n)
    );

    assign dq_oe  = !ce_n && !oe_n && rd_en;
    assign dq_out = dq_oe ? rdata : 16'h0000;

    a_r1_standby_tristate: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> !dq_oe);

    a_r2_output_disable: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe && dq_out == 16'h0000);

    a_r9_powerdown_tristate: assert property (@(posedge clk) disable iff (rst)
        !rp_n |-> !dq_oe);

endmodule

// File: tb/flash_bus_ctrl_bench.sv
module flash_bus_ctrl_bench;
    localparam int ADDR_W = 8, T_RPL = 5, T_PHWL = 12, T_ERASE = 20, T_WRITE = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] dq_in = '0, dq_out;
    logic dq_oe, ry_by_n;
    int total = 0, bad = 0, cycles = 0;

    always #10 clk = ~clk;

    flash_bus_ctrl u_flash_bus_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .ry_by_n(ry_by_n)
    );

    // {command byte, address, expected read word}
    localparam logic [31:0] VEC [6] = '{
        32'h90_00_00A5, 32'h90_01_0C3E, 32'h90_02_0000,
        32'h90_07_0000, 32'h70_00_0080, 32'hFF_03_FFFF
    };

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            total++; bad++;
            $display("FAIL watchdog all-reqs actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        ce_n = 1'b0; we_n = 1'b0; addr = a; dq_in = d;
        cyc(1);
        we_n = 1'b1;
        cyc(1);
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d, output logic oe);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #1; d = dq_out; oe = dq_oe;
        oe_n = 1'b1;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] d; logic oe;
        rd(a, d, oe);
        chk(req, {15'd0, oe}, 16'd1);
        chk(req, d, exp);
    endtask

    task automatic pd_pulse(input int n);
        rp_n = 1'b0; cyc(n); rp_n = 1'b1;
    endtask

    initial begin
        logic [15:0] d; logic oe;
        cyc(3); rst = 1'b0; cyc(1);

        // reset state
        chk("R2 reset oe", {15'd0, dq_oe}, 16'd0);
        chk("R5 reset ready", {15'd0, ry_by_n}, 16'd1);
        rdchk("R2 reset array", 8'h00, 16'hFFFF);

        // R1 standby: ce_n high with oe_n low
        ce_n = 1'b1; oe_n = 1'b0; #1;
        chk("R1 standby tristate", {15'd0, dq_oe}, 16'd0);
        oe_n = 1'b1;

        // table of mode commands and reads (R3, R4)
        foreach (VEC[i]) begin
            wr(8'h00, {8'h00, VEC[i][31:24]});
            rdchk("R4 R3 vector", VEC[i][23:16], VEC[i][15:0]);
        end

        // R3 strobe ignored while ce_n high
        wr(8'h00, 16'h0090);
        ce_n = 1'b1; we_n = 1'b0; dq_in = 16'h00FF; cyc(1); we_n = 1'b1; cyc(2);
        rdchk("R3 ce high ignored", 8'h00, 16'h00A5);

        // R5 word program
        wr(8'h00, 16'h0040); wr(8'h03, 16'h1234);
        chk("R5 busy pin", {15'd0, ry_by_n}, 16'd0);
        wr(8'h00, 16'h00FF);                       // R12 ignored while busy
        rdchk("R5 busy status", 8'h03, 16'h0000);
        cyc(T_WRITE + 2);
        chk("R5 ready after", {15'd0, ry_by_n}, 16'd1);
        rdchk("R12 stayed status", 8'h03, 16'h0080);
        wr(8'h00, 16'h00FF);
        rdchk("R5 programmed", 8'h03, 16'h1234);

        // R6 block erase with R12 ignore during busy
        wr(8'h00, 16'h0040); wr(8'h04, 16'hAAAA); cyc(T_WRITE + 2);
        wr(8'h00, 16'h0020); wr(8'h05, 16'h00D0);
        wr(8'h00, 16'h0090);
        cyc(T_ERASE + 4);
        rdchk("R12 cmd during erase", 8'h00, 16'h0080);
        wr(8'h00, 16'h00FF);
        rdchk("R6 block erased", 8'h04, 16'hFFFF);
        rdchk("R6 other block kept", 8'h03, 16'h1234);

        // R7 bad confirm and clear
        wr(8'h00, 16'h0020); wr(8'h04, 16'h0011);
        rdchk("R7 error bits", 8'h00, 16'h00B0);
        wr(8'h00, 16'h0050);
        rdchk("R7 cleared", 8'h00, 16'h0080);

        // R8 deselect during program
        wr(8'h00, 16'h0040); wr(8'h06, 16'h5A5A);
        ce_n = 1'b1; cyc(T_WRITE + 3);
        wr(8'h00, 16'h00FF);
        rdchk("R8 completed deselected", 8'h06, 16'h5A5A);

        // R9 short pulse changes nothing
        wr(8'h00, 16'h0090);
        rp_n = 1'b0; cyc(1); rd(8'h00, d, oe);
        chk("R9 pd tristate", {15'd0, oe}, 16'd0);
        cyc(1); rp_n = 1'b1; cyc(2);
        rdchk("R9 short pulse", 8'h00, 16'h00A5);

        // R9 accepted power-down resets mode and status
        wr(8'h00, 16'h0020); wr(8'h00, 16'h0011);
        pd_pulse(T_RPL + 2); cyc(T_PHWL + 3);
        rdchk("R9 array after pd", 8'h09, 16'hFFFF);
        wr(8'h00, 16'h0070);
        rdchk("R9 status after pd", 8'h00, 16'h0080);

        // R11 wake windows
        pd_pulse(T_RPL + 2);
        rd(8'h00, d, oe);
        chk("R11 read blocked", {15'd0, oe}, 16'd0);
        wr(8'h00, 16'h0090);
        cyc(T_PHWL + 3);
        rdchk("R11 early cmd ignored", 8'h09, 16'hFFFF);

        // R10 abort during erase of block 8..11
        wr(8'h00, 16'h0020); wr(8'h09, 16'h00D0);
        cyc(3);
        rp_n = 1'b0; cyc(T_RPL + 2);
        chk("R10 busy in pd", {15'd0, ry_by_n}, 16'd0);
        rp_n = 1'b1; cyc(1);
        chk("R10 busy in wake", {15'd0, ry_by_n}, 16'd0);
        cyc(T_PHWL + 3);
        chk("R10 ready after wake", {15'd0, ry_by_n}, 16'd1);
        rdchk("R10 corrupt word", 8'h09, 16'hDEAD);
        rdchk("R10 other block kept", 8'h03, 16'h1234);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule